// File: doc/BRIEF.md
# ADC Conversion Sequencer with Programmable Acquisition

This block is the digital controller of a successive-approximation analog-to-digital converter with 10-bit resolution. Software pulses a start request. The block then either ends sampling and converts at once, or keeps the sample/hold tracking for a programmed number of conversion-clock periods and then converts without further action. The analog comparator sits outside the block. It is seen as one input bit that reports whether the sampled voltage is at or above the trial code the block presents.

The conversion clock period (TAD) comes from the system clock, divided by a factor chosen with a 3-bit select. It can also come from the rising edges of a free-running RC tick from an unrelated domain, which is synchronized first. A conversion takes eleven TAD periods. Ten of them decide one bit each, most significant first, and the eleventh moves the code into the result register. On completion the busy output drops, the sticky interrupt flag sets and the sample/hold tracks the input again. Software can abort a conversion that is running.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While rst_n is low and after its release: busy = 0, irq = 0, result = 0, sample_en = 1.
- R2: With acq_sel = 000, a start makes sample_en low from the next edge, and busy stays high for exactly 11 TAD periods.
- R3: With acq_sel non-zero, busy rises and sample_en stays high for N TAD periods before the conversion's 11 TAD. N is 2, 4, 6, 8, 12, 16 or 20 for codes 001 to 111. No output separates the two phases except sample_en.
- R4: TAD from the system clock lasts 2, 8 or 32 cycles for clk_sel 000, 001, 010 and 4, 16 or 64 cycles for 100, 101, 110. Codes 011 and 111 select the RC tick.
- R5: In RC mode, each rising edge of rc_tick, after a two-flop synchronizer, gives one TAD. Without edges, the sequence does not advance.
- R6: The trial code starts at 10'h200 and bits are decided MSB first. cmp_in = 1 keeps the bit under trial, and cmp_in = 0 clears it. The result equals the binary-search code.
- R7: On the edge that ends the 11th conversion TAD, result is loaded, busy clears, irq sets and sample_en returns high. result changes at no other time.
- R8: go_clr while busy aborts to idle on the next edge, with result unchanged and irq not set, even on the edge the conversion would have completed.
- R9: irq stays set until irq_clr. If a completion and irq_clr fall on the same edge, irq ends up set.
- R10: go_set while busy is ignored, and the conversion timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_set | input | 1 | Start request pulse |
| go_clr | input | 1 | Abort request (software clears busy) |
| acq_sel | input | 3 | Acquisition window select |
| clk_sel | input | 3 | Conversion clock select |
| rc_tick | input | 1 | Asynchronous RC clock |
| cmp_in | input | 1 | Comparator: input at or above trial code |
| irq_clr | input | 1 | Clears the interrupt flag |
| busy | output | 1 | High from start until completion or abort |
| sample_en | output | 1 | Sample/hold tracking |
| trial | output | 10 | Code under trial for the DAC |
| result | output | 10 | Last completed conversion |
| irq | output | 1 | Sticky completion flag |

## Verification
Completion of a conversion can fall on the same edge as a software request: either an interrupt-flag clear or an abort. The bench counts clock cycles from the start edge with the fastest divider so that irq_clr, and in a separate run go_clr, is high exactly during the cycle whose closing edge would complete the conversion. The clear must lose, leaving irq set with the new result. The abort must win, leaving the old result and no flag.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_set,
  input  logic           go_clr,
  input  logic [2:0]     acq_sel,
  input  logic [2:0]     clk_sel,
  input  logic           rc_tick,
  input  logic           cmp_in,
  input  logic           irq_clr,
  output logic           busy,
  output logic           sample_en,
  output logic [RES-1:0] trial,
  output logic [RES-1:0] result,
  output logic           irq
);
  localparam logic [RES-1:0] MSB = {1'b1, {(RES-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_CONV} st_t;
  st_t st;

  logic [1:0]     rc_sync;
  logic           rc_prev;
  logic [5:0]     dcnt;
  logic [4:0]     acq_cnt;
  logic [RES-1:0] sar, mask;

  function automatic logic [4:0] acq_len(input logic [2:0] s);
    case (s)
      3'd1: return 5'd2;
      3'd2: return 5'd4;
      3'd3: return 5'd6;
      3'd4: return 5'd8;
      3'd5: return 5'd12;
      3'd6: return 5'd16;
      default: return 5'd20;
    endcase
  endfunction

  wire       rc_mode  = &clk_sel[1:0];
  wire [2:0] shamt    = {clk_sel[1:0], 1'b0} + {2'b00, clk_sel[2]};
  wire [6:0] div      = 7'd2 << shamt;
  wire       sys_tick = ({1'b0, dcnt} == div - 7'd1);
  wire       rc_edge  = rc_sync[1] & ~rc_prev;
  wire       tad      = busy & (rc_mode ? rc_edge : sys_tick);

  assign busy      = (st != S_IDLE);
  assign sample_en = (st != S_CONV);
  assign trial     = sar;

  always_ff @(posedge clk) begin
    if (!rst_n) {rc_prev, rc_sync} <= 3'b000;
    else        {rc_prev, rc_sync} <= {rc_sync[1], rc_sync[0], rc_tick};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || sys_tick) dcnt <= '0;
    else                             dcnt <= dcnt + 6'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      acq_cnt <= '0;
      sar     <= '0;
      mask    <= '0;
      result  <= '0;
      irq     <= 1'b0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      case (st)
        S_IDLE:
          if (go_set) begin
            if (acq_sel == 3'd0) begin
              st   <= S_CONV;
              sar  <= MSB;
              mask <= MSB;
            end else begin
              st      <= S_ACQ;
              acq_cnt <= acq_len(acq_sel);
            end
          end
        S_ACQ:
          if (go_clr) st <= S_IDLE;
          else if (tad) begin
            if (acq_cnt == 5'd1) begin
              st   <= S_CONV;
              sar  <= MSB;
              mask <= MSB;
            end else acq_cnt <= acq_cnt - 5'd1;
          end
        default:
          if (go_clr) st <= S_IDLE;
          else if (tad) begin
            if (mask == '0) begin
              result <= sar;
              irq    <= 1'b1;
              st     <= S_IDLE;
            end else begin
              sar  <= (cmp_in ? sar : (sar & ~mask)) | (mask >> 1);
              mask <= mask >> 1;
            end
          end
      endcase
    end
  end
endmodule

module adc_seq_ctrl_chk #(
  parameter int RES = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           go_clr,
  input logic           irq_clr,
  input logic           busy,
  input logic           sample_en,
  input logic [RES-1:0] trial,
  input logic [RES-1:0] result,
  input logic           irq
);
  localparam logic [RES-1:0] MSB = {1'b1, {(RES-1){1'b0}}};

  AST_IDLE_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sample_en); // R7
  AST_CONV_STARTS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_en) |-> (busy && trial == MSB)); // R6
  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_clr && !irq_clr) |=> (!busy && irq == $past(irq))); // R8
  AST_ABORT_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_clr) |=> $stable(result)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R9
  AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> ($fell(busy) && irq)); // R7
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES(RES)) u_chk (.*);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  logic clk = 0, rst_n = 0, go_set = 0, go_clr = 0, rc_tick = 0, irq_clr = 0;
  logic [2:0] acq_sel = 0, clk_sel = 0;
  logic [9:0] vin = 0;
  logic busy, sample_en, irq, cmp_in;
  logic [9:0] trial, result;
  logic rc_run = 0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;
  always begin #70; if (rc_run) rc_tick = ~rc_tick; end
  assign cmp_in = (vin >= trial);

  adc_seq_ctrl dut (.clk, .rst_n, .go_set, .go_clr, .acq_sel, .clk_sel, .rc_tick,
                    .cmp_in, .irq_clr, .busy, .sample_en, .trial, .result, .irq);

  // {acq_sel, clk_sel, vin, acquisition cycles, conversion cycles}
  localparam logic [47:0] VEC [10] = '{
    {3'd0, 3'b000, 10'h155, 16'd0,   16'd22},
    {3'd0, 3'b100, 10'h3FF, 16'd0,   16'd44},
    {3'd0, 3'b001, 10'h000, 16'd0,   16'd88},
    {3'd1, 3'b000, 10'h2AA, 16'd4,   16'd22},
    {3'd4, 3'b101, 10'h200, 16'd128, 16'd176},
    {3'd7, 3'b010, 10'h1FF, 16'd640, 16'd352},
    {3'd5, 3'b110, 10'h001, 16'd768, 16'd704},
    {3'd6, 3'b000, 10'h3FE, 16'd32,  16'd22},
    {3'd2, 3'b100, 10'h123, 16'd16,  16'd44},
    {3'd3, 3'b001, 10'h0C7, 16'd48,  16'd88}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start();
    @(negedge clk) go_set = 1;
    @(posedge clk); #1 go_set = 0;
  endtask

  task automatic clear_irq();
    @(negedge clk) irq_clr = 1;
    @(negedge clk) irq_clr = 0;
  endtask

  task automatic run(output int na, output int nc);
    na = 0; nc = 0;
    start();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!busy) break;
      if (sample_en) na++; else nc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int na, nc;
    repeat (3) @(negedge clk);
    chk(busy == 0 && irq == 0 && result == 0 && sample_en == 1, "R1 reset", result, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && irq == 0 && sample_en == 1, "R1 after release", busy, 0);

    for (int v = 0; v < 10; v++) begin
      clear_irq();
      acq_sel = VEC[v][47:45]; clk_sel = VEC[v][44:42]; vin = VEC[v][41:32];
      run(na, nc);
      chk(na == int'(VEC[v][31:16]), "R3 acquisition cycles", na, VEC[v][31:16]);
      chk(nc == int'(VEC[v][15:0]), "R2/R4 conversion cycles", nc, VEC[v][15:0]);
      chk(result == vin, "R6 result", result, vin);
      chk(irq && sample_en && !busy, "R7 completion state", irq, 1);
    end

    repeat (10) @(negedge clk);
    chk(irq == 1, "R9 sticky", irq, 1);
    clear_irq();
    chk(irq == 0, "R9 clear", irq, 0);

    acq_sel = 0; clk_sel = 3'b000; vin = 10'h0AA;
    start(); na = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      go_set = (na == 5);
      if (!busy) break;
      na++;
    end
    go_set = 0;
    chk(na == 22 && result == 10'h0AA, "R10 go ignored while busy", na, 22);
    clear_irq();

    vin = 10'h3C3;
    start();
    repeat (10) @(negedge clk);
    go_clr = 1;
    @(negedge clk) go_clr = 0;
    chk(!busy && sample_en, "R8 abort idles", busy, 0);
    chk(result == 10'h0AA, "R8 abort keeps result", result, 10'h0AA);
    repeat (30) @(negedge clk);
    chk(irq == 0, "R8 abort no irq", irq, 0);

    vin = 10'h055; run(na, nc);
    vin = 10'h2F0;
    start();
    repeat (22) @(negedge clk);
    irq_clr = 1;
    @(negedge clk) irq_clr = 0;
    chk(!busy && irq == 1, "R9 set wins over clear", irq, 1);
    chk(result == 10'h2F0, "R7 result at coincident clear", result, 10'h2F0);

    clear_irq();
    vin = 10'h111;
    start();
    repeat (22) @(negedge clk);
    go_clr = 1;
    @(negedge clk) go_clr = 0;
    chk(!busy && irq == 0 && result == 10'h2F0, "R8 abort wins over completion", result, 10'h2F0);

    clk_sel = 3'b011; vin = 10'h19C; rc_run = 1;
    run(na, nc);
    chk(nc >= 68 && nc <= 84, "R5 RC conversion length", nc, 77);
    chk(result == 10'h19C && irq, "R5 RC result", result, 10'h19C);
    rc_run = 0;
    clk_sel = 3'b111;
    start();
    repeat (60) @(negedge clk);
    chk(busy && !sample_en, "R5 no RC edges stalls", busy, 1);
    go_clr = 1;
    @(negedge clk) go_clr = 0;
    chk(!busy, "R8 abort in RC mode", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule